// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block is a small direct-mapped cache that sits between one processor and a shared broadcast bus. Each line holds a single data word, the full address it belongs to, and a valid flag. The processor presents one request at a time and waits for a one-cycle completion pulse. A read that finds its address resident completes locally. Every other request, meaning a read miss or any write, becomes a packet on the bus addressed to memory. The controller then waits for a memory acknowledge that carries its own source number.

Because memory is always current under write-through, a fill simply overwrites whatever the indexed line held. A write updates the line only when the acknowledge arrives, never when the request is issued. The controller also watches memory-write packets that other caches put on the bus and clears any of its own lines that match. If such a clear hits the line of a request that is still waiting for the bus, the request withdraws and its lookup is taken again.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address misses. `bus_req` and `cpu_done` are low out of reset.
- R2: A read whose address is resident pulses `cpu_done` with the stored word two clock edges after the request is taken, and raises no `bus_req`.
- R3: A read miss raises `bus_req` with `out_type` 2'b00, the request address, and `out_src` equal to the cache's own number. When the matching acknowledge arrives, the returned word goes to the processor and into the line, so the next read of that address hits.
- R4: A write sends `out_type` 2'b01 carrying the address and data whether it hits or misses. On the acknowledge the line takes the written word and `cpu_done` pulses, so a later read hits with that word.
- R5: Line index is address bits [2:0], and a hit needs the full stored address to match. A fill replaces the indexed line, so an address that previously occupied that index misses afterwards.
- R6: Only a packet with type 2'b10 and `in_src` equal to the cache's own number completes a pending request. An acknowledge for another source, or any other packet type, leaves `cpu_done` low.
- R7: A memory-write packet (2'b01) from another source whose address matches a valid line clears that line. A memory-write from the cache's own source, one whose address differs from the stored address, or a memory-read packet leaves the line valid.
- R8: If a snooped clear hits the pending request's line index while the controller waits for grant, `bus_req` drops for one cycle. The lookup is then redone and `bus_req` returns with the same packet. A clear at another index leaves `bus_req` high.
- R9: While `bus_req` is high without `bus_grant`, the outgoing packet stays unchanged. `bus_req` falls in the cycle after `bus_grant` is seen.
- R10: `cpu_done` is a single-cycle pulse and is never high together with `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request strobe, taken when idle |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| bus_req | output | 1 | Request for the bus, held until granted |
| bus_grant | input | 1 | Bus grant |
| out_type | output | 2 | Outgoing packet type (00 read, 01 write) |
| out_addr | output | ADDR_W | Outgoing packet address |
| out_data | output | DATA_W | Outgoing packet data |
| out_src | output | SRC_W | Outgoing packet source number |
| in_valid | input | 1 | Broadcast packet present |
| in_type | input | 2 | Broadcast packet type (10 acknowledge) |
| in_addr | input | ADDR_W | Broadcast packet address |
| in_data | input | DATA_W | Broadcast packet data |
| in_src | input | SRC_W | Broadcast packet source number |

## Verification
The assertions watch several bus-side rules on every cycle:
- the outgoing packet stays frozen and `bus_req` stays up while the request waits quietly for grant;
- `bus_req` drops after a grant;
- only read or write types go out under this cache's number;
- a foreign acknowledge never completes a request;
- the completion pulse lasts one cycle and never overlaps `bus_req`.

The cache contents can only be judged through later requests, so the bench scenarios are what show hits, conflict replacement, snoop clears and the cases that must not clear, write data becoming visible, and the withdrawn-and-reissued request.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    PK_RD  = 2'b00,
    PK_WR  = 2'b01,
    PK_ACK = 2'b10
  } pkt_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT_GNT,
    ST_WAIT_ACK
  } ctl_state_t;
endpackage

// File: rtl/wtc_rx_decode.sv
module wtc_rx_decode
  import wtc_pkg::*;
#(
  parameter int SRC_W = 2,
  parameter int MY_ID = 1
) (
  input  logic             in_valid,
  input  logic [1:0]       in_type,
  input  logic [SRC_W-1:0] in_src,
  output logic             own_ack,
  output logic             peer_wr
);
  logic from_self;

  assign from_self = (in_src == SRC_W'(MY_ID));
  assign own_ack   = in_valid && (in_type == PK_ACK) && from_self;
  assign peer_wr   = in_valid && (in_type == PK_WR) && !from_self;
endmodule

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int ADDR_W = 16,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  input  logic              snp_en,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr
);
  logic [LINES-1:0]  valid_q;
  logic [ADDR_W-1:0] tag_q [LINES];
  logic [IDX_W-1:0]  lk_idx, snp_idx, fill_idx;

  assign lk_idx   = lk_addr[IDX_W-1:0];
  assign snp_idx  = snp_addr[IDX_W-1:0];
  assign fill_idx = fill_addr[IDX_W-1:0];

  assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_addr);
  assign snp_hit = snp_en && valid_q[snp_idx] && (tag_q[snp_idx] == snp_addr);

  // valid flags: fill wins over a clear of the same line
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_en && fill_idx == IDX_W'(i))
          valid_q[i] <= 1'b1;
        else if (snp_hit && snp_idx == IDX_W'(i))
          valid_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en)
      tag_q[fill_idx] <= fill_addr;
  end
endmodule

// File: rtl/wtc_line_ram.sv
module wtc_line_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [1:0]        out_type,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hit,
  output logic [IDX_W-1:0]  ram_raddr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              fill_en,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  input  logic              own_ack,
  input  logic [DATA_W-1:0] ack_data,
  input  logic              snp_hit,
  input  logic [IDX_W-1:0]  snp_idx,
  output ctl_state_t        state_o
);
  ctl_state_t        state;
  logic              p_we;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_wdata;
  logic              kill_pend;

  assign lk_addr   = p_addr;
  assign state_o   = state;
  assign kill_pend = snp_hit && (snp_idx == p_addr[IDX_W-1:0]);
  assign ram_raddr = (state == ST_IDLE) ? cpu_addr[IDX_W-1:0] : p_addr[IDX_W-1:0];
  assign fill_en   = (state == ST_WAIT_ACK) && own_ack;
  assign fill_addr = p_addr;
  assign fill_data = p_we ? p_wdata : ack_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      p_we      <= 1'b0;
      p_addr    <= '0;
      p_wdata   <= '0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      bus_req   <= 1'b0;
      out_type  <= '0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cpu_req) begin
            p_we    <= cpu_we;
            p_addr  <= cpu_addr;
            p_wdata <= cpu_wdata;
            state   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (kill_pend) begin
            state <= ST_CHECK;
          end else if (!p_we && lk_hit) begin
            cpu_done  <= 1'b1;
            cpu_rdata <= ram_rdata;
            state     <= ST_IDLE;
          end else begin
            bus_req  <= 1'b1;
            out_type <= p_we ? PK_WR : PK_RD;
            out_addr <= p_addr;
            out_data <= p_we ? p_wdata : '0;
            state    <= ST_WAIT_GNT;
          end
        end
        ST_WAIT_GNT: begin
          if (bus_grant) begin
            bus_req <= 1'b0;
            state   <= ST_WAIT_ACK;
          end else if (kill_pend) begin
            bus_req <= 1'b0;
            state   <= ST_CHECK;
          end
        end
        ST_WAIT_ACK: begin
          if (own_ack) begin
            cpu_done  <= 1'b1;
            cpu_rdata <= fill_data;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LINES  = 8,
  parameter int SRC_W  = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [1:0]        out_type,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [SRC_W-1:0]  out_src,
  input  logic              in_valid,
  input  logic [1:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SRC_W-1:0]  in_src
);
  localparam int IDX_W = $clog2(LINES);

  logic              own_ack, peer_wr, lk_hit, snp_hit, fill_en;
  logic [ADDR_W-1:0] lk_addr, fill_addr;
  logic [DATA_W-1:0] fill_data, ram_rdata;
  logic [IDX_W-1:0]  ram_raddr;
  ctl_state_t        state_w;

  assign out_src = SRC_W'(MY_ID);

  wtc_rx_decode #(.SRC_W(SRC_W), .MY_ID(MY_ID)) u_rx (
    .in_valid(in_valid), .in_type(in_type), .in_src(in_src),
    .own_ack(own_ack), .peer_wr(peer_wr)
  );

  wtc_tag_store #(.ADDR_W(ADDR_W), .LINES(LINES)) u_tags (
    .clk(clk), .rst(rst),
    .lk_addr(lk_addr), .lk_hit(lk_hit),
    .snp_en(peer_wr), .snp_addr(in_addr), .snp_hit(snp_hit),
    .fill_en(fill_en), .fill_addr(fill_addr)
  );

  wtc_line_ram #(.DATA_W(DATA_W), .DEPTH(LINES)) u_ram (
    .clk(clk), .raddr(ram_raddr), .rdata(ram_rdata),
    .we(fill_en), .waddr(fill_addr[IDX_W-1:0]), .wdata(fill_data)
  );

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .out_type(out_type), .out_addr(out_addr), .out_data(out_data),
    .lk_addr(lk_addr), .lk_hit(lk_hit),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
    .own_ack(own_ack), .ack_data(in_data),
    .snp_hit(snp_hit), .snp_idx(in_addr[IDX_W-1:0]),
    .state_o(state_w)
  );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SRC_W  = 2,
  parameter int MY_ID  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_done,
  input logic              bus_req,
  input logic              bus_grant,
  input logic [1:0]        out_type,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data,
  input logic [SRC_W-1:0]  out_src,
  input logic              in_valid,
  input logic [1:0]        in_type,
  input logic [SRC_W-1:0]  in_src,
  input ctl_state_t        state
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |-> !bus_req);

  p_hold_until_grant_r9: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_grant && !in_valid |=>
      bus_req && $stable(out_addr) && $stable(out_type) && $stable(out_data));

  p_drop_on_grant_r9: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_grant |=> !bus_req);

  p_legal_packet_r3: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (out_type == 2'b00 || out_type == 2'b01) && out_src == SRC_W'(MY_ID));

  p_foreign_ack_r6: assert property (@(posedge clk) disable iff (rst)
    state == ST_WAIT_ACK && in_valid && in_type == 2'b10 && in_src != SRC_W'(MY_ID)
      |=> !cpu_done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  p_done_no_bus_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !bus_req);
endmodule

bind wt_snoop_cache wtc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .MY_ID(MY_ID)
) u_chk (
  .clk(clk), .rst(rst), .cpu_done(cpu_done), .bus_req(bus_req),
  .bus_grant(bus_grant), .out_type(out_type), .out_addr(out_addr),
  .out_data(out_data), .out_src(out_src), .in_valid(in_valid),
  .in_type(in_type), .in_src(in_src), .state(state_w)
);

// File: tb/wt_snoop_cache_test.sv
module wt_snoop_cache_test;
  localparam int AW = 16, DW = 16, SW = 2, ME = 1;

  logic          clk = 0, rst = 1;
  logic          cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req, bus_grant = 0;
  logic [1:0]    out_type;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic [SW-1:0] out_src;
  logic          in_valid = 0;
  logic [1:0]    in_type = '0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic [SW-1:0] in_src = '0;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wt_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(8), .SRC_W(SW), .MY_ID(ME)) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant), .out_type(out_type),
    .out_addr(out_addr), .out_data(out_data), .out_src(out_src),
    .in_valid(in_valid), .in_type(in_type), .in_addr(in_addr),
    .in_data(in_data), .in_src(in_src)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic expect_hit(input logic [DW-1:0] d, input string req);
    @(negedge clk);
    chk(cpu_done == 1'b1, req, 32'(cpu_done), 1);
    chk(cpu_rdata == d, req, 32'(cpu_rdata), 32'(d));
    chk(bus_req == 1'b0, req, 32'(bus_req), 0);
  endtask

  task automatic expect_bus(input logic [1:0] t, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input string req);
    @(negedge clk);
    chk(bus_req == 1'b1, req, 32'(bus_req), 1);
    chk(out_type == t, req, 32'(out_type), 32'(t));
    chk(out_addr == a, req, 32'(out_addr), 32'(a));
    chk(out_src == SW'(ME), req, 32'(out_src), ME);
    if (t == 2'b01) chk(out_data == d, req, 32'(out_data), 32'(d));
  endtask

  task automatic grant(input string req);
    bus_grant = 1;
    @(negedge clk);
    bus_grant = 0;
    chk(bus_req == 1'b0, req, 32'(bus_req), 0);
  endtask

  task automatic send_pkt(input logic [1:0] t, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [SW-1:0] s);
    in_valid = 1; in_type = t; in_addr = a; in_data = d; in_src = s;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic ack(input logic [DW-1:0] d, input bit chk_data, input string req);
    send_pkt(2'b10, '0, d, SW'(ME));
    chk(cpu_done == 1'b1, req, 32'(cpu_done), 1);
    if (chk_data) chk(cpu_rdata == d, req, 32'(cpu_rdata), 32'(d));
  endtask

  task automatic serve_read(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    issue(0, a, '0);
    expect_bus(2'b00, a, '0, req);
    grant(req);
    ack(d, 1, req);
  endtask

  task automatic t_reset;
    chk(bus_req == 1'b0, "R1 bus_req idle", 32'(bus_req), 0);
    chk(cpu_done == 1'b0, "R1 done idle", 32'(cpu_done), 0);
    serve_read(16'h0013, 16'h1111, "R1 first read misses");
    @(negedge clk);
    chk(cpu_done == 1'b0, "R10 single pulse", 32'(cpu_done), 0);
  endtask

  task automatic t_read_hit;
    issue(0, 16'h0013, '0);
    expect_hit(16'h1111, "R2 read hit");
    issue(0, 16'h0013, '0);
    expect_hit(16'h1111, "R3 fill kept");
  endtask

  task automatic t_conflict;
    serve_read(16'h0023, 16'h2222, "R5 fill idx3");
    issue(0, 16'h0023, '0);
    expect_hit(16'h2222, "R5 new line hits");
    serve_read(16'h0013, 16'h1111, "R5 old tag misses");
  endtask

  task automatic t_write;
    issue(1, 16'h0046, 16'hBEEF);
    expect_bus(2'b01, 16'h0046, 16'hBEEF, "R4 write miss packet");
    grant("R4 write miss grant");
    ack(16'h0000, 0, "R4 write miss ack");
    issue(0, 16'h0046, '0);
    expect_hit(16'hBEEF, "R4 written word");
    issue(1, 16'h0046, 16'h1234);
    expect_bus(2'b01, 16'h0046, 16'h1234, "R4 write hit packet");
    grant("R4 write hit grant");
    ack(16'h0000, 0, "R4 write hit ack");
    issue(0, 16'h0046, '0);
    expect_hit(16'h1234, "R4 rewritten word");
  endtask

  task automatic t_hold;
    issue(0, 16'h0057, '0);
    expect_bus(2'b00, 16'h0057, '0, "R9 request");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(bus_req == 1'b1 && out_addr == 16'h0057 && out_type == 2'b00,
          "R9 held", 32'(out_addr), 32'h0057);
    end
    grant("R9 drop after grant");
    ack(16'h5757, 1, "R9 ack");
  endtask

  task automatic t_foreign_ack;
    issue(0, 16'h0061, '0);
    expect_bus(2'b00, 16'h0061, '0, "R6 request");
    grant("R6 grant");
    send_pkt(2'b10, '0, 16'hDEAD, 2'd2);
    chk(cpu_done == 1'b0, "R6 foreign ack", 32'(cpu_done), 0);
    send_pkt(2'b00, '0, 16'hDEAD, SW'(ME));
    chk(cpu_done == 1'b0, "R6 wrong type", 32'(cpu_done), 0);
    ack(16'h6161, 1, "R6 own ack");
  endtask

  task automatic t_snoop;
    send_pkt(2'b01, 16'h0013, 16'h9999, 2'd2);
    serve_read(16'h0013, 16'h1111, "R7 peer write clears");
    send_pkt(2'b01, 16'h0013, 16'h9999, SW'(ME));
    issue(0, 16'h0013, '0);
    expect_hit(16'h1111, "R7 own write ignored");
    send_pkt(2'b01, 16'h0093, 16'h9999, 2'd2);
    issue(0, 16'h0013, '0);
    expect_hit(16'h1111, "R7 other tag ignored");
    send_pkt(2'b00, 16'h0013, 16'h9999, 2'd2);
    issue(0, 16'h0013, '0);
    expect_hit(16'h1111, "R7 peer read ignored");
  endtask

  task automatic t_recheck;
    issue(0, 16'h0033, '0);
    expect_bus(2'b00, 16'h0033, '0, "R8 request");
    send_pkt(2'b01, 16'h0057, 16'h0, 2'd2);
    chk(bus_req == 1'b1, "R8 other index keeps req", 32'(bus_req), 1);
    send_pkt(2'b01, 16'h0013, 16'h0, 2'd2);
    chk(bus_req == 1'b0, "R8 withdraw", 32'(bus_req), 0);
    @(negedge clk);
    chk(bus_req == 1'b1 && out_addr == 16'h0033 && out_type == 2'b00,
        "R8 reissue", 32'(out_addr), 32'h0033);
    grant("R8 grant");
    ack(16'h3333, 1, "R8 ack");
    serve_read(16'h0057, 16'h5757, "R7 peer write at idx7 cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_read_hit();
    t_conflict();
    t_write();
    t_hold();
    t_foreign_ack();
    t_snoop();
    t_recheck();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule